// File: doc/BRIEF.md
# Multidrop Address Wake-Up Receiver

This block filters the characters coming out of a UART character deserializer for a station on a multidrop bus. With multidrop mode enabled, each character carries a ninth bit that marks it as an address (1) or as data (0). That bit sits where a parity bit would normally be. The bus master sends an address character and then any number of data characters. Each address character closes the previous block and opens a new one. Station addresses are 8 bits wide, so up to 256 stations can share one bus.

The receiver keeps watching the line even when software has disabled it. Every address character raises the ready flag and, if enabled, the interrupt. Software then reads the address, decides whether the block is meant for this station, and sets the receiver enable. Data characters are accepted only while that enable is set. An optional hardware compare mode passes only the address characters that equal the station address. With multidrop mode off, every character is accepted subject only to the receiver enable, and the flag bit is ignored.

The accepted character is held together with an address indication until the CPU acknowledges the read. A new character that arrives before that acknowledge sets an overrun flag and replaces the held one.

Top module: `mdrop_wake_rx`

## Requirements
- R1: After reset, ready, overrun, interrupt, address indication and held character are all 0.
- R2: With multidrop mode off and the receiver enabled, every valid character is accepted whatever its flag bit: ready goes to 1, the character is held, and the address indication is 0.
- R3: With multidrop mode off and the receiver disabled, valid characters are ignored and ready stays 0.
- R4: With multidrop mode on and compare mode off, a character whose flag bit is 1 (address) is accepted even when the receiver is disabled, with the address indication set to 1.
- R5: With multidrop mode on, a character whose flag bit is 0 (data) is accepted only while the receiver is enabled, with the address indication 0. While the receiver is disabled it leaves ready at 0.
- R6: The interrupt output is 1 exactly when ready is 1 and the interrupt enable is 1.
- R7: A read acknowledge with no character accepted in the same cycle clears ready and overrun on the next cycle.
- R8: A character accepted while ready is 1 and no acknowledge is given sets overrun. The new character and its address indication replace the held ones.
- R9: A character accepted in the same cycle as an acknowledge leaves ready at 1 and overrun at 0, and the new character is held.
- R10: With multidrop and compare mode both on, an address character is accepted only if it equals the station address. Data characters still depend only on the receiver enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mdrop_en_i | input | 1 | Multidrop mode enable |
| rx_en_i | input | 1 | Receiver enable, set by software |
| irq_en_i | input | 1 | Interrupt enable |
| cmp_en_i | input | 1 | Hardware station address compare enable |
| station_i | input | 8 | Station address used for the compare |
| char_valid_i | input | 1 | Character strobe from the deserializer |
| char_i | input | 8 | Received character |
| flag_i | input | 1 | Ninth bit, in the parity position: 1 address, 0 data |
| rd_ack_i | input | 1 | CPU read acknowledge |
| rdy_o | output | 1 | Character ready |
| ovr_o | output | 1 | Overrun |
| irq_o | output | 1 | Interrupt request |
| addr_o | output | 1 | The held character is an address |
| data_o | output | 8 | Held character |

## Verification
Ready, overrun, the held character and the address indication are all registered, so they change one clock edge after the strobe or acknowledge that causes them. The interrupt follows ready and the interrupt enable without any added delay. The bench drives inputs on the falling edge and samples the outputs on the next falling edge, which is one rising edge after the stimulus. Those sampled values are compared with a bench model that advances on the same rising edge. Directed checks apply the same one-edge rule, and the interrupt enable check is sampled without a clock edge in between.

// File: rtl/mdrop_pkg.sv
package mdrop_pkg;
  localparam int unsigned CHAR_W_DEF = 8;

  typedef enum logic {
    KIND_DATA = 1'b0,
    KIND_ADDR = 1'b1
  } char_kind_e;

  function automatic char_kind_e kind_of(input logic mode, input logic flag);
    return (mode && flag) ? KIND_ADDR : KIND_DATA;
  endfunction
endpackage

// File: rtl/mdrop_class.sv
module mdrop_class
  import mdrop_pkg::*;
#(
  parameter int unsigned CHAR_W = CHAR_W_DEF
) (
  input  logic              valid_i,
  input  logic              mode_i,
  input  logic              flag_i,
  input  logic              rx_en_i,
  input  logic              cmp_en_i,
  input  logic [CHAR_W-1:0] char_i,
  input  logic [CHAR_W-1:0] station_i,
  output logic              accept_o,
  output char_kind_e        kind_o
);
  logic hit;

  assign hit = (char_i == station_i);

  always_comb begin
    kind_o = kind_of(mode_i, flag_i);
    if (!valid_i)
      accept_o = 1'b0;
    else if (kind_o == KIND_ADDR)
      accept_o = !cmp_en_i || hit;  // address wakes a disabled receiver
    else
      accept_o = rx_en_i;
  end
endmodule

// File: rtl/mdrop_hold.sv
module mdrop_hold
  import mdrop_pkg::*;
#(
  parameter int unsigned CHAR_W = CHAR_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  char_kind_e        kind_i,
  input  logic [CHAR_W-1:0] char_i,
  input  logic              rd_ack_i,
  output logic              rdy_o,
  output logic              ovr_o,
  output logic              addr_o,
  output logic [CHAR_W-1:0] data_o
);
  logic              rdy_q, ovr_q, addr_q;
  logic [CHAR_W-1:0] data_q;
  logic              rdy_d, ovr_d;

  always_comb begin
    rdy_d = rdy_q;
    ovr_d = ovr_q;
    if (accept_i) begin
      rdy_d = 1'b1;
      if (rd_ack_i)   ovr_d = 1'b0;
      else if (rdy_q) ovr_d = 1'b1;
    end else if (rd_ack_i) begin
      rdy_d = 1'b0;
      ovr_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_q  <= 1'b0;
      ovr_q  <= 1'b0;
      addr_q <= 1'b0;
      data_q <= '0;
    end else begin
      rdy_q <= rdy_d;
      ovr_q <= ovr_d;
      if (accept_i) begin
        data_q <= char_i;
        addr_q <= (kind_i == KIND_ADDR);
      end
    end
  end

  assign rdy_o  = rdy_q;
  assign ovr_o  = ovr_q;
  assign addr_o = addr_q;
  assign data_o = data_q;

  // R7
  ack_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ack_i && !accept_i) |=> (!rdy_q && !ovr_q));
  // R8
  overrun_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_i && rdy_q && !rd_ack_i) |=> (ovr_q && rdy_q && data_q == $past(char_i)));
  // R9
  ack_and_new_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_i && rd_ack_i) |=> (rdy_q && !ovr_q));
endmodule

// File: rtl/mdrop_wake_rx.sv
module mdrop_wake_rx
  import mdrop_pkg::*;
#(
  parameter int unsigned CHAR_W = CHAR_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mdrop_en_i,
  input  logic              rx_en_i,
  input  logic              irq_en_i,
  input  logic              cmp_en_i,
  input  logic [CHAR_W-1:0] station_i,
  input  logic              char_valid_i,
  input  logic [CHAR_W-1:0] char_i,
  input  logic              flag_i,
  input  logic              rd_ack_i,
  output logic              rdy_o,
  output logic              ovr_o,
  output logic              irq_o,
  output logic              addr_o,
  output logic [CHAR_W-1:0] data_o
);
  logic       accept;
  char_kind_e kind;

  mdrop_class #(.CHAR_W(CHAR_W)) u_class (
    .valid_i   (char_valid_i),
    .mode_i    (mdrop_en_i),
    .flag_i    (flag_i),
    .rx_en_i   (rx_en_i),
    .cmp_en_i  (cmp_en_i),
    .char_i    (char_i),
    .station_i (station_i),
    .accept_o  (accept),
    .kind_o    (kind)
  );

  mdrop_hold #(.CHAR_W(CHAR_W)) u_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .kind_i   (kind),
    .char_i   (char_i),
    .rd_ack_i (rd_ack_i),
    .rdy_o    (rdy_o),
    .ovr_o    (ovr_o),
    .addr_o   (addr_o),
    .data_o   (data_o)
  );

  assign irq_o = rdy_o && irq_en_i;

  // R2
  plain_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (char_valid_i && !mdrop_en_i && rx_en_i) |=> (rdy_o && !addr_o));
  // R3
  plain_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (char_valid_i && !mdrop_en_i && !rx_en_i && !rdy_o) |=> !rdy_o);
  // R4
  addr_wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (char_valid_i && mdrop_en_i && flag_i && !cmp_en_i) |=> (rdy_o && addr_o));
  // R5
  data_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (char_valid_i && mdrop_en_i && !flag_i && !rx_en_i && !rdy_o) |=> !rdy_o);
  // R10
  cmp_miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (char_valid_i && mdrop_en_i && flag_i && cmp_en_i && char_i != station_i && !rdy_o)
      |=> !rdy_o);
  // R6
  irq_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdy_o |-> !irq_o);
endmodule

// File: tb/tb_mdrop_wake_rx.sv
`timescale 1ns/1ps
module tb_mdrop_wake_rx;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       mode = 0, rx_en = 0, irq_en = 0, cmp_en = 0, valid = 0, flag = 0, ack = 0;
  logic [7:0] station = 8'h00, ch = 8'h00;
  logic       rdy, ovr, irq, addr;
  logic [7:0] data;
  int         checks = 0, errors = 0;
  bit         done = 0;

  always #4 clk = ~clk;

  mdrop_wake_rx dut (
    .clk_i(clk), .rst_ni(rst_ni), .mdrop_en_i(mode), .rx_en_i(rx_en),
    .irq_en_i(irq_en), .cmp_en_i(cmp_en), .station_i(station),
    .char_valid_i(valid), .char_i(ch), .flag_i(flag), .rd_ack_i(ack),
    .rdy_o(rdy), .ovr_o(ovr), .irq_o(irq), .addr_o(addr), .data_o(data)
  );

  // bench model built from the requirements
  logic       m_rdy, m_ovr, m_addr;
  logic [7:0] m_data;

  function automatic logic exp_accept(logic v, logic md, logic f, logic re,
                                      logic ce, logic [7:0] c, logic [7:0] st);
    if (!v) return 1'b0;
    if (md && f) return !ce || (c == st);  // R4 R10
    return re;                              // R2 R3 R5
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_rdy <= 0; m_ovr <= 0; m_addr <= 0; m_data <= 0;
    end else if (exp_accept(valid, mode, flag, rx_en, cmp_en, ch, station)) begin
      m_rdy  <= 1'b1;
      m_ovr  <= ack ? 1'b0 : (m_rdy ? 1'b1 : m_ovr);
      m_data <= ch;
      m_addr <= mode && flag;
    end else if (ack) begin
      m_rdy <= 0; m_ovr <= 0;
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    valid = 0; ack = 0;
  endtask

  task automatic send(logic f, logic [7:0] c);
    valid = 1; flag = f; ch = c;
    step();
  endtask

  task automatic do_ack();
    ack = 1;
    step();
  endtask

  initial begin
    #(8 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    if (!done) begin
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    #20;
    @(negedge clk);
    chk("R1 rdy", rdy, 0); chk("R1 ovr", ovr, 0); chk("R1 irq", irq, 0);
    chk("R1 addr", addr, 0); chk("R1 data", data, 8'h00);
    rst_ni = 1;
    @(negedge clk);

    // mode off
    rx_en = 1; send(1'b1, 8'hA5);
    chk("R2 rdy", rdy, 1); chk("R2 data", data, 8'hA5); chk("R2 addr", addr, 0);
    do_ack();
    rx_en = 0; send(1'b0, 8'h3C);
    chk("R3 rdy", rdy, 0); chk("R3 data", data, 8'hA5);

    // mode on, address wakes disabled receiver
    mode = 1; irq_en = 1; send(1'b1, 8'h42);
    chk("R4 rdy", rdy, 1); chk("R4 addr", addr, 1); chk("R4 data", data, 8'h42);
    chk("R6 irq on", irq, 1);
    irq_en = 0; #1;
    chk("R6 irq off", irq, 0);
    do_ack();
    chk("R7 rdy", rdy, 0);

    // data gating
    send(1'b0, 8'h11);
    chk("R5 gated rdy", rdy, 0); chk("R5 gated data", data, 8'h42);
    rx_en = 1; send(1'b0, 8'h22);
    chk("R5 rdy", rdy, 1); chk("R5 addr", addr, 0); chk("R5 data", data, 8'h22);

    // overrun
    send(1'b0, 8'h33);
    chk("R8 ovr", ovr, 1); chk("R8 data", data, 8'h33); chk("R8 rdy", rdy, 1);
    do_ack();
    chk("R7 rdy after ovr", rdy, 0); chk("R7 ovr", ovr, 0);

    // accept with simultaneous ack
    send(1'b0, 8'h44);
    ack = 1; send(1'b1, 8'h55);
    chk("R9 rdy", rdy, 1); chk("R9 ovr", ovr, 0); chk("R9 data", data, 8'h55);
    chk("R9 addr", addr, 1);
    do_ack();

    // hardware compare
    cmp_en = 1; station = 8'h07; rx_en = 0;
    send(1'b1, 8'h08);
    chk("R10 miss rdy", rdy, 0);
    send(1'b1, 8'h07);
    chk("R10 hit rdy", rdy, 1); chk("R10 hit addr", addr, 1); chk("R10 hit data", data, 8'h07);
    do_ack();
    rx_en = 1; send(1'b0, 8'h09);
    chk("R10 data rdy", rdy, 1); chk("R10 data addr", addr, 0);
    do_ack();

    // constrained random against the model
    for (int i = 0; i < 4000; i++) begin
      chk("R7 rdy", rdy, m_rdy);
      chk("R8 ovr", ovr, m_ovr);
      chk("R2 data", data, m_data);
      chk("R5 addr", addr, m_addr);
      chk("R6 irq", irq, m_rdy && irq_en);
      if (i % 97 == 0) mode = $urandom_range(0, 1);
      if (i % 53 == 0) cmp_en = $urandom_range(0, 3) == 0;
      rx_en   = $urandom_range(0, 3) != 0;
      irq_en  = $urandom_range(0, 1);
      valid   = $urandom_range(0, 2) != 0;
      flag    = $urandom_range(0, 3) == 0;
      station = 8'h07;
      ch      = ($urandom_range(0, 1) == 1) ? 8'h07 : 8'($urandom);
      ack     = $urandom_range(0, 2) == 0;
      @(posedge clk);
      @(negedge clk);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule